// File: doc/BRIEF.md
# Lane-Masked Dual-Port Shape-Selectable RAM

This block is a synchronous RAM with two ports that share a single fixed store. The store is organised as 9-bit lanes. At elaboration each port chooses a word shape of 1, 2, 4 or 8 lanes. With the production lane count of 65536 these shapes give 64K×9, 32K×18, 16K×36 and 8K×72. The two ports may choose different shapes. A word at address `n` on a port with `L` lanes occupies lanes `n*L` to `n*L+L-1`, with lane `k` of the word on data bits `[9k+8:9k]`.

Each port decides on every clock whether it reads or writes, using its write-enable pin alone. There is no read strobe. A write stores only the lanes whose lane-select bit is set. Reads are registered, and a port's read data holds its last value through that port's write cycles.

A wide mode can also be set at elaboration. In this mode port A is a 144-bit write-only port and port B is a 144-bit read-only port. The sixteen lane selects of the wide write are port B's eight select bits placed above port A's eight. Both ports run on one shared clock.

Top module: `bdp_ram`

## Requirements
- R1: While `rst_n` is low at a clock edge, both read-data outputs become zero.
- R2: A port whose `we` is low at an edge performs a read: its `rdata` after that edge holds the word currently stored at its address.
- R3: A write changes lane `k` only when `we` and select bit `k` are both high. Lanes whose select bit is low keep their previous contents.
- R4: Select bit `k` governs data bits `[9k+8:9k]` of the port word. For example, bit 7 of an 8-lane port governs bits `[71:63]`.
- R5: A 1-lane (×9) port ignores its one select pin, so a write with `we` high stores the lane even when the select is low.
- R6: In a cycle where a port writes, that port's `rdata` keeps the value it had before the edge.
- R7: Both ports address one shared lane store. Lane `k` of word `n` on an `L`-lane port is the same storage as the 1-lane word at `n*L+k`, or lane `(n*L+k) mod M` of word `(n*L+k)/M` on an `M`-lane port.
- R8: The two ports can read or write different locations in the same cycle without disturbing each other.
- R9: In wide mode, lane select `k` of the 144-bit write is `{be_b, be_a}[k]`. Port B reads every cycle and never writes, whatever `we_b` is, and `rdata_a` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset of the read registers |
| we_a | input | 1 | Port A write enable; low means read |
| addr_a | input | AWA | Port A word address |
| wdata_a | input | 9*LANES_A | Port A write word |
| be_a | input | BEA | Port A lane selects (lanes 0..7 in wide mode) |
| rdata_a | output | 9*LANES_A | Port A registered read word |
| we_b | input | 1 | Port B write enable; low means read (ignored in wide mode) |
| addr_b | input | AWB | Port B word address |
| wdata_b | input | 9*LANES_B | Port B write word (unused in wide mode) |
| be_b | input | BEB | Port B lane selects (lanes 8..15 of the wide write) |
| rdata_b | output | 9*LANES_B | Port B registered read word |

## Verification
The hardest case to reach from the ports is a partial write by a port of one shape that lands inside a word later read by a port of a different shape. A fault there is only visible when the neighbouring lanes hold known, distinct contents. The stimulus therefore first fills whole words through one port. It then makes narrow or sparse-mask writes through the other port, sometimes in the same cycle on disjoint lanes. Finally it reads back through both shapes, so that a wrong lane offset, a mask bit tied to the wrong lane, or a leak into an unselected lane changes a compared word. The wide instance repeats this with split masks taken from both select vectors, and with a write strobe on the read-only port aimed at a word that is read back afterwards.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

    localparam int LANE_W = 9;

    // number of lane-select pins a port of the given lane count exposes
    function automatic int sel_width(input int lanes);
        return (lanes > 8) ? 8 : lanes;
    endfunction

endpackage

// File: rtl/bdp_lane_mask.sv
module bdp_lane_mask #(
    parameter int LANES = 4,
    parameter int BEW   = 4
) (
    input  logic             we,
    input  logic [BEW-1:0]   be,
    output logic [LANES-1:0] lane_en
);

    generate
        if (LANES == 1) begin : g_single
            // a one-lane word has no lane choice: the strobe alone decides
            assign lane_en = we;
        end else begin : g_multi
            assign lane_en = {LANES{we}} & be;
        end
    endgenerate

endmodule

// File: rtl/bdp_read_reg.sv
module bdp_read_reg #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (rd_en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/bdp_ram.sv
module bdp_ram
    import bdp_pkg::*;
#(
    parameter int TOTAL_LANES = 4096,
    parameter int LANES_A     = 4,
    parameter int LANES_B     = 4,
    parameter bit WIDE        = 1'b0,
    localparam int BEA = sel_width(LANES_A),
    localparam int BEB = sel_width(LANES_B),
    localparam int AWA = $clog2(TOTAL_LANES / LANES_A),
    localparam int AWB = $clog2(TOTAL_LANES / LANES_B),
    localparam int DWA = LANE_W * LANES_A,
    localparam int DWB = LANE_W * LANES_B
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we_a,
    input  logic [AWA-1:0] addr_a,
    input  logic [DWA-1:0] wdata_a,
    input  logic [BEA-1:0] be_a,
    output logic [DWA-1:0] rdata_a,
    input  logic           we_b,
    input  logic [AWB-1:0] addr_b,
    input  logic [DWB-1:0] wdata_b,
    input  logic [BEB-1:0] be_b,
    output logic [DWB-1:0] rdata_b
);

    localparam int LAW = $clog2(TOTAL_LANES);

    logic [LANE_W-1:0]  mem [TOTAL_LANES];
    logic [LAW-1:0]     base_a, base_b;
    logic [LANES_A-1:0] en_a;
    logic [LANES_B-1:0] en_b;
    logic [DWA-1:0]     rd_word_a;
    logic [DWB-1:0]     rd_word_b;
    logic               rd_en_a, rd_en_b;

    // first lane covered by each port's word
    always_comb begin
        base_a = LAW'(addr_a) * LAW'(LANES_A);
        base_b = LAW'(addr_b) * LAW'(LANES_B);
    end

    generate
        if (WIDE) begin : g_wide
            // sixteen selects: B's vector on top of A's
            bdp_lane_mask #(.LANES(LANES_A), .BEW(LANES_A)) u_mask_a (
                .we(we_a), .be({be_b, be_a}), .lane_en(en_a)
            );
            assign en_b    = '0;
            assign rd_en_a = 1'b0;
            assign rd_en_b = 1'b1;
        end else begin : g_tdp
            bdp_lane_mask #(.LANES(LANES_A), .BEW(BEA)) u_mask_a (
                .we(we_a), .be(be_a), .lane_en(en_a)
            );
            bdp_lane_mask #(.LANES(LANES_B), .BEW(BEB)) u_mask_b (
                .we(we_b), .be(be_b), .lane_en(en_b)
            );
            assign rd_en_a = !we_a;
            assign rd_en_b = !we_b;
        end
    endgenerate

    // lane store, written per lane from both ports
    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES_A; k++) begin
            if (en_a[k]) begin
                mem[base_a + LAW'(k)] <= wdata_a[LANE_W*k +: LANE_W];
            end
        end
        for (int k = 0; k < LANES_B; k++) begin
            if (en_b[k]) begin
                mem[base_b + LAW'(k)] <= wdata_b[LANE_W*k +: LANE_W];
            end
        end
    end

    always_comb begin
        for (int k = 0; k < LANES_A; k++) begin
            rd_word_a[LANE_W*k +: LANE_W] = mem[base_a + LAW'(k)];
        end
        for (int k = 0; k < LANES_B; k++) begin
            rd_word_b[LANE_W*k +: LANE_W] = mem[base_b + LAW'(k)];
        end
    end

    bdp_read_reg #(.W(DWA)) u_rd_a (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en_a), .d(rd_word_a), .q(rdata_a)
    );
    bdp_read_reg #(.W(DWB)) u_rd_b (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en_b), .d(rd_word_b), .q(rdata_b)
    );

    // R6: a writing port keeps its read word
    p_hold_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!WIDE && we_a) |=> $stable(rdata_a));
    p_hold_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!WIDE && we_b) |=> $stable(rdata_b));

    // R3: no lane is ever selected without the write strobe
    p_sel_needs_we_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a != '0) |-> we_a);

    // R9: in wide mode port A never produces read data
    p_wide_a_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        WIDE |-> (rdata_a == '0));

    // R2: full-word write followed by a read of the same word returns it
    p_write_then_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!WIDE && $past(rst_n) && $past(rst_n, 2)
         && $past(we_a, 2) && (&$past(en_a, 2)) && !$past(we_b, 2)
         && !$past(we_a) && !$past(we_b)
         && ($past(addr_a) == $past(addr_a, 2)))
        |-> (rdata_a == $past(wdata_a, 2)));

endmodule

// File: tb/sim_bdp_ram.sv
module sim_bdp_ram;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 64;

    typedef struct {
        int           due;
        int           inst;
        int           port;
        logic [143:0] exp;
        string        req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   cyc = 0;
    int   nchk = 0;
    int   nfail = 0;
    item_t sq[$];

    // generic stimulus view: [instance][port]
    logic         gwe   [3][2];
    int           gaddr [3][2];
    logic [143:0] gdat  [3][2];
    logic [15:0]  gbe   [3][2];
    bit           gchk  [3][2];
    string        greq  [3][2];
    logic [143:0] last  [3][2];
    logic [8:0]   rf    [3][NL];
    int           LN    [3][2] = '{'{4, 1}, '{2, 8}, '{16, 16}};

    logic        we0a, we0b, we1a, we1b, we2a, we2b;
    logic [3:0]  a0a;  logic [5:0]  a0b;
    logic [4:0]  a1a;  logic [2:0]  a1b;
    logic [1:0]  a2a;  logic [1:0]  a2b;
    logic [35:0] d0a;  logic [8:0]  d0b;
    logic [17:0] d1a;  logic [71:0] d1b;
    logic [143:0] d2a, d2b;
    logic [3:0]  be0a; logic [0:0]  be0b;
    logic [1:0]  be1a; logic [7:0]  be1b;
    logic [7:0]  be2a, be2b;
    logic [35:0] r0a;  logic [8:0]  r0b;
    logic [17:0] r1a;  logic [71:0] r1b;
    logic [143:0] r2a, r2b;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always_comb begin
        we0a = gwe[0][0]; a0a = 4'(gaddr[0][0]); d0a = gdat[0][0][35:0]; be0a = gbe[0][0][3:0];
        we0b = gwe[0][1]; a0b = 6'(gaddr[0][1]); d0b = gdat[0][1][8:0];  be0b = gbe[0][1][0:0];
        we1a = gwe[1][0]; a1a = 5'(gaddr[1][0]); d1a = gdat[1][0][17:0]; be1a = gbe[1][0][1:0];
        we1b = gwe[1][1]; a1b = 3'(gaddr[1][1]); d1b = gdat[1][1][71:0]; be1b = gbe[1][1][7:0];
        we2a = gwe[2][0]; a2a = 2'(gaddr[2][0]); d2a = gdat[2][0];       be2a = gbe[2][0][7:0];
        we2b = gwe[2][1]; a2b = 2'(gaddr[2][1]); d2b = gdat[2][1];       be2b = gbe[2][1][7:0];
    end

    bdp_ram #(.TOTAL_LANES(NL), .LANES_A(4), .LANES_B(1), .WIDE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n),
        .we_a(we0a), .addr_a(a0a), .wdata_a(d0a), .be_a(be0a), .rdata_a(r0a),
        .we_b(we0b), .addr_b(a0b), .wdata_b(d0b), .be_b(be0b), .rdata_b(r0b)
    );
    bdp_ram #(.TOTAL_LANES(NL), .LANES_A(2), .LANES_B(8), .WIDE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n),
        .we_a(we1a), .addr_a(a1a), .wdata_a(d1a), .be_a(be1a), .rdata_a(r1a),
        .we_b(we1b), .addr_b(a1b), .wdata_b(d1b), .be_b(be1b), .rdata_b(r1b)
    );
    bdp_ram #(.TOTAL_LANES(NL), .LANES_A(16), .LANES_B(16), .WIDE(1'b1)) u2 (
        .clk(clk), .rst_n(rst_n),
        .we_a(we2a), .addr_a(a2a), .wdata_a(d2a), .be_a(be2a), .rdata_a(r2a),
        .we_b(we2b), .addr_b(a2b), .wdata_b(d2b), .be_b(be2b), .rdata_b(r2b)
    );

    function automatic logic [143:0] actual(input int i, input int p);
        case ({i[1:0], p[0]})
            3'b000: return 144'(r0a);
            3'b001: return 144'(r0b);
            3'b010: return 144'(r1a);
            3'b011: return 144'(r1b);
            3'b100: return r2a;
            default: return r2b;
        endcase
    endfunction

    task automatic check(input string req, input logic [143:0] act, input logic [143:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // monitor: compare queued expectations once their cycle has come
    always @(negedge clk) begin
        while (sq.size() > 0 && sq[0].due <= cyc) begin
            item_t it;
            it = sq.pop_front();
            check($sformatf("%s inst%0d port%0d", it.req, it.inst, it.port),
                  actual(it.inst, it.port), it.exp);
        end
    end

    task automatic clr();
        for (int i = 0; i < 3; i++) begin
            for (int p = 0; p < 2; p++) begin
                gwe[i][p] = 1'b0; gchk[i][p] = 1'b0; gbe[i][p] = '0; gdat[i][p] = '0;
            end
        end
    endtask

    // driver: model one cycle, queue expected read words, apply the edge
    task automatic step();
        for (int i = 0; i < 3; i++) begin
            for (int p = 0; p < 2; p++) begin
                int  ln;
                bit  rd;
                ln = LN[i][p];
                rd = (i == 2) ? (p == 1) : !gwe[i][p];
                if (rd) begin
                    logic [143:0] w;
                    w = '0;
                    for (int k = 0; k < ln; k++) w[9*k +: 9] = rf[i][gaddr[i][p]*ln + k];
                    last[i][p] = w;
                end
                if (gchk[i][p]) sq.push_back('{cyc + 1, i, p, last[i][p], greq[i][p]});
            end
        end
        for (int i = 0; i < 3; i++) begin
            for (int p = 0; p < 2; p++) begin
                int          ln;
                logic [15:0] sel;
                ln = LN[i][p];
                sel = (i == 2) ? {gbe[2][1][7:0], gbe[2][0][7:0]} : gbe[i][p];
                if (gwe[i][p] && !(i == 2 && p == 1)) begin
                    for (int k = 0; k < ln; k++) begin
                        if (ln == 1 || sel[k]) rf[i][gaddr[i][p]*ln + k] = gdat[i][p][9*k +: 9];
                    end
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        clr();
    endtask

    task automatic wr(input int i, input int p, input int a, input logic [143:0] d, input logic [15:0] be);
        gwe[i][p] = 1'b1; gaddr[i][p] = a; gdat[i][p] = d; gbe[i][p] = be;
    endtask

    task automatic rd(input int i, input int p, input int a, input string req);
        gwe[i][p] = 1'b0; gaddr[i][p] = a; gchk[i][p] = 1'b1; greq[i][p] = req;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            for (int p = 0; p < 2; p++) begin
                last[i][p] = '0; gaddr[i][p] = 0;
            end
        end
        clr();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset clears every read word
        check("R1 u0a", 144'(r0a), '0); check("R1 u0b", 144'(r0b), '0);
        check("R1 u1a", 144'(r1a), '0); check("R1 u1b", 144'(r1b), '0);
        check("R1 u2a", r2a, '0);       check("R1 u2b", r2b, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // ---- u0: A x36, B x9
        wr(0, 0, 5, 144'h0_1111_2222, 16'hF); step();
        wr(0, 0, 3, 144'h1_2345_6789, 16'hF); wr(0, 1, 5, 144'h1AB, 16'h1); step();
        rd(0, 0, 3, "R2"); rd(0, 1, 5, "R8"); step();
        wr(0, 0, 3, 144'hF_EDCB_A987, 16'b0101); gchk[0][0] = 1'b1; greq[0][0] = "R6"; step();
        rd(0, 0, 3, "R3"); step();
        rd(0, 1, 13, "R7"); step();
        rd(0, 1, 15, "R4"); step();
        wr(0, 1, 20, 144'h155, 16'h0); gchk[0][1] = 1'b1; greq[0][1] = "R6"; step();
        rd(0, 0, 5, "R5"); step();

        // ---- u1: A x18, B x72
        wr(1, 1, 0, 144'h12_3456_789A_BCDE_F012, 16'hFF); step();
        wr(1, 1, 1, 144'hAB_CDEF_0123_4567_89AB, 16'hFF); wr(1, 0, 1, 144'h2_5A5A, 16'b10); step();
        rd(1, 1, 0, "R7"); rd(1, 0, 1, "R3"); step();
        wr(1, 1, 1, 144'hFF_0000_0000_0000_01FF, 16'h81); step();
        rd(1, 1, 1, "R4"); rd(1, 0, 4, "R7"); step();

        // ---- u2: wide write on A, wide read on B
        wr(2, 0, 1, {4{36'h1_0203_0405}}, 16'h0); gbe[2][0] = 16'hFF; gbe[2][1] = 16'hFF; step();
        wr(2, 0, 2, {4{36'h9_8765_4321}}, 16'h0); gbe[2][0] = 16'hFF; gbe[2][1] = 16'hFF; step();
        wr(2, 0, 1, {4{36'hA_AAAA_5555}}, 16'h0); gbe[2][0] = 16'h0F; gbe[2][1] = 16'hF0;
        gwe[2][1] = 1'b1; gaddr[2][1] = 2; gdat[2][1] = {4{36'h0_DEAD_BEEF}}; gbe[2][1] = 16'hF0;
        gchk[2][1] = 1'b1; greq[2][1] = "R9"; step();
        rd(2, 1, 1, "R9"); gchk[2][0] = 1'b1; greq[2][0] = "R9"; step();
        rd(2, 1, 2, "R9"); step();

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule